// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block is the register-level front end for a byte-wide nonvolatile data array. A CPU reaches it through a small register window: a control register, a data register and a two-part address register. Reads complete at once. The byte at the current address lands in the data register on the clock edge that takes the read request. Each programming operation needs two steps. First a self-expiring arm bit is set. Then the start bit must follow while the arm bit is still set. A two-bit field selects one of three operations: erase followed by write, erase alone, or write alone. Each operation has its own duration, counted in clock cycles.

When an operation has run its full duration, the controller issues a single-cycle command to the array. The command carries the address and data that were captured at start, plus one flag for erase and one for program. The array clears a byte to 0xFF on erase and ANDs the new byte into the cell on program. While an operation is in flight, the controller ignores changes to the address and the mode, and it ignores read requests. It also drives a stall request so the CPU waits after a read or a start. A ready interrupt line stays high for as long as the interrupt enable is set and the array is idle. A reset does not cut short an operation in flight.

Top module: `nvm_ctrl`

## Requirements
- R1: Writing 1 to the arm bit (control bit 2) sets it. The arm bit then reads as 1 for exactly ARM_WIN (4) cycles and clears by itself.
- R2: A control write with the start bit (bit 1) set begins an operation only if the arm bit is 1 at that edge and no operation is running. Otherwise the write starts nothing.
- R3: The mode field (control bits 5:4) of the start write selects the operation: 00 is erase then write, 01 is erase only, 10 is write only. A start with 11 is ignored.
- R4: The busy flag (control bit 1) reads as 1 for exactly T_ATOMIC cycles in mode 00, and for T_SPLIT cycles in modes 01 and 10. After that the hardware clears it.
- R5: In the cycle after busy clears, arr_cmd_valid pulses for one cycle. It carries the captured address and data, with arr_cmd_erase set for modes 00 and 01 and arr_cmd_program set for modes 00 and 10.
- R6: While busy, writes to the address register are ignored, writes to the mode field are ignored, and read requests are ignored.
- R7: A control write with the read bit (bit 0) set, made while idle, loads the array byte at the current address into the data register on that edge. Stall then reads as 1 for RD_STALL (4) cycles.
- R8: An accepted start raises stall for WR_STALL (2) cycles.
- R9: ready_irq is 1 exactly when the interrupt enable (control bit 3) is set and no operation is running.
- R10: Reset clears the arm bit, the interrupt enable, the address and the data. It also returns the mode field to 00 unless an operation is running; a running operation completes and commits normally.
- R11: The array applies erase as 0xFF and program as an AND with the new byte. Write-only mode on a byte that was never erased therefore leaves old AND new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 address low, 3 address high |
| reg_wdata | input | 8 | Register write data |
| ctrl_q | output | 8 | Control readback: 5:4 mode, 3 irq enable, 2 arm, 1 busy |
| data_q | output | 8 | Data register |
| addr_q | output | ADDR_W | Address register |
| arr_addr | output | ADDR_W | Array address: captured address while busy or committing, else addr_q |
| arr_rdata | input | 8 | Array read data at arr_addr |
| arr_wdata | output | 8 | Byte captured at start |
| arr_cmd_valid | output | 1 | One-cycle commit command |
| arr_cmd_erase | output | 1 | Commit clears the byte to 0xFF |
| arr_cmd_program | output | 1 | Commit ANDs arr_wdata into the byte |
| stall | output | 1 | CPU stall request |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
The bench probes both edges of the arm window. A start on the fourth cycle after arming must be taken, and a start on the fifth must be dropped. A counter that is off by one would shift either result. It measures busy length per mode and compares the committed byte for each mode. Write-only on a non-erased cell must show the AND; a design that erased first would return the new byte unchanged. It makes address, mode and read writes during an operation and checks that none of them landed. It pulses reset mid-operation to confirm the operation still commits and that the mode field is held.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    MODE_ATOMIC = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_RSVD   = 2'b11
  } nvm_mode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_ALO  = 2'd2;
  localparam logic [1:0] SEL_AHI  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_PROG = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IRQ  = 3;
  localparam int CB_MODE = 4;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  output logic armed_o
);
  localparam int AW = $clog2(WIN + 1);

  logic [AW-1:0] left_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (set_i) begin
      armed_q <= 1'b1;
      left_q  <= AW'(WIN - 1);
    end else if (armed_q) begin
      if (left_q == '0) armed_q <= 1'b0;
      else              left_q  <= left_q - 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int T_ATOMIC = 27200,
  parameter int T_SPLIT  = 14400
) (
  input  logic                clk,
  input  logic                start_i,
  input  nvm_pkg::nvm_mode_e  mode_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                erase_o,
  output logic                program_o
);
  import nvm_pkg::*;

  localparam int T_MAX = (T_ATOMIC > T_SPLIT) ? T_ATOMIC : T_SPLIT;
  localparam int CW    = $clog2(T_MAX + 1);

  // No reset: an operation under way must survive a reset pulse.
  logic [CW-1:0] left_q  = '0;
  logic          busy_q  = 1'b0;
  logic          done_q  = 1'b0;
  logic          erase_q = 1'b0;
  logic          prog_q  = 1'b0;

  logic [CW-1:0] load_val;
  assign load_val = (mode_i == MODE_ATOMIC) ? CW'(T_ATOMIC - 1) : CW'(T_SPLIT - 1);

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (start_i) begin
      busy_q  <= 1'b1;
      left_q  <= load_val;
      erase_q <= (mode_i != MODE_WRITE);
      prog_q  <= (mode_i != MODE_ERASE);
    end else if (busy_q) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign erase_o   = erase_q;
  assign program_o = prog_q;
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int RD_N = 4,
  parameter int WR_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  input  logic wr_i,
  output logic stall_o
);
  localparam int NMAX = (RD_N > WR_N) ? RD_N : WR_N;
  localparam int SW   = $clog2(NMAX + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (rd_i)         cnt_q <= SW'(RD_N);
    else if (wr_i)         cnt_q <= SW'(WR_N);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int ADDR_W   = 9,
  parameter int ARM_WIN  = 4,
  parameter int T_ATOMIC = 27200,
  parameter int T_SPLIT  = 14400,
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        data_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        arr_wdata,
  output logic              arr_cmd_valid,
  output logic              arr_cmd_erase,
  output logic              arr_cmd_program,
  output logic              stall,
  output logic              ready_irq
);
  import nvm_pkg::*;

  localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  logic      ctrl_we, armed, busy, done, hold;
  logic      start, rd_go;
  nvm_mode_e wr_mode, mode_q;
  logic      irq_en_q;

  logic [ADDR_W-1:0] op_addr_q = '0;
  logic [7:0]        op_data_q = '0;

  assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);
  assign wr_mode = nvm_mode_e'(reg_wdata[CB_MODE +: 2]);
  assign hold    = busy || done;
  assign start   = ctrl_we && reg_wdata[CB_PROG] && armed && !busy
                   && (wr_mode != MODE_RSVD) && !rst;
  assign rd_go   = ctrl_we && reg_wdata[CB_RD] && !hold && !rst;

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .set_i   (ctrl_we && reg_wdata[CB_ARM]),
    .armed_o (armed)
  );

  nvm_prog_timer #(.T_ATOMIC(T_ATOMIC), .T_SPLIT(T_SPLIT)) u_tmr (
    .clk       (clk),
    .start_i   (start),
    .mode_i    (wr_mode),
    .busy_o    (busy),
    .done_o    (done),
    .erase_o   (arr_cmd_erase),
    .program_o (arr_cmd_program)
  );

  nvm_stall_gen #(.RD_N(RD_STALL), .WR_N(WR_STALL)) u_stall (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_go),
    .wr_i    (start),
    .stall_o (stall)
  );

  // Control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q <= 1'b0;
      if (!busy) mode_q <= MODE_ATOMIC;
    end else if (ctrl_we) begin
      irq_en_q <= reg_wdata[CB_IRQ];
      if (!busy) mode_q <= wr_mode;
    end
  end

  // Data register
  always_ff @(posedge clk) begin
    if (rst)                                 data_q <= '0;
    else if (rd_go)                          data_q <= arr_rdata;
    else if (reg_we && reg_sel == SEL_DATA)  data_q <= reg_wdata;
  end

  // Address register, split by width
  generate
    if (ADDR_W > 8) begin : g_addr_wide
      always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else if (reg_we && !busy && reg_sel == SEL_ALO) addr_q[7:0] <= reg_wdata;
        else if (reg_we && !busy && reg_sel == SEL_AHI) addr_q[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
      end
    end else begin : g_addr_narrow
      always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else if (reg_we && !busy && reg_sel == SEL_ALO) addr_q <= reg_wdata[ADDR_W-1:0];
      end
    end
  endgenerate

  // Operation capture (kept through reset)
  always_ff @(posedge clk) begin
    if (start) begin
      op_addr_q <= addr_q;
      op_data_q <= data_q;
    end
  end

  assign arr_addr      = hold ? op_addr_q : addr_q;
  assign arr_wdata     = op_data_q;
  assign arr_cmd_valid = done;
  assign ready_irq     = irq_en_q && !busy;
  assign ctrl_q        = {2'b00, mode_q, irq_en_q, armed, busy, 1'b0};
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_we,
  input logic [1:0]        wr_mode,
  input logic              wr_prog,
  input logic              wr_rd,
  input logic              busy,
  input logic              armed,
  input logic [ADDR_W-1:0] addr_q,
  input logic              stall,
  input logic              ready_irq,
  input logic              cmd_valid,
  input logic              cmd_erase,
  input logic              cmd_program
);
  // R2
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  // R3
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wr_prog && wr_mode == 2'b11) |=> !$rose(busy));

  // R6
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(rst)) |-> $stable(addr_q));

  // R8
  start_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> stall);

  // R7
  read_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wr_rd && !busy && !cmd_valid) |=> stall);

  // R5
  commit_flags_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((cmd_erase || cmd_program) && !busy));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready_irq |-> !busy);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_we     (reg_we && reg_sel == 2'd0),
  .wr_mode     (reg_wdata[5:4]),
  .wr_prog     (reg_wdata[1]),
  .wr_rd       (reg_wdata[0]),
  .busy        (ctrl_q[1]),
  .armed       (ctrl_q[2]),
  .addr_q      (addr_q),
  .stall       (stall),
  .ready_irq   (ready_irq),
  .cmd_valid   (arr_cmd_valid),
  .cmd_erase   (arr_cmd_erase),
  .cmd_program (arr_cmd_program)
);

// File: tb/sim_nvm_ctrl.sv
module sim_nvm_ctrl;
  localparam int AW = 9;
  localparam int TA = 40;
  localparam int TS = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [1:0]    sel = '0;
  logic [7:0]    wd = '0;
  logic [7:0]    ctrl, data, arr_wdata, arr_rdata;
  logic [AW-1:0] addr, arr_addr;
  logic          cv, ce, cp, stall, irq;
  logic [7:0]    mem [0:(1<<AW)-1];
  int            total = 0;
  int            fails = 0;
  bit            finished = 0;

  always #4 clk = ~clk;

  nvm_ctrl #(.ADDR_W(AW), .T_ATOMIC(TA), .T_SPLIT(TS)) u0 (
    .clk(clk), .rst(rst), .reg_we(we), .reg_sel(sel), .reg_wdata(wd),
    .ctrl_q(ctrl), .data_q(data), .addr_q(addr), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .arr_wdata(arr_wdata), .arr_cmd_valid(cv),
    .arr_cmd_erase(ce), .arr_cmd_program(cp), .stall(stall), .ready_irq(irq)
  );

  // Behavioural array (R11)
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk)
    if (cv) mem[arr_addr] <= (ce ? 8'hFF : mem[arr_addr]) & (cp ? arr_wdata : 8'hFF);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    we = 1'b1; sel = s; wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_addr(input logic [AW-1:0] a);
    wr(2'd2, a[7:0]);
    wr(2'd3, {7'b0, a[8]});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && ctrl[1]; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 ctrl", ctrl, 8'h00);
    chk("R10 data", data, 8'h00);
    chk("R10 addr", addr, 0);
    chk("R10 stall/irq/cmd", {stall, irq, cv}, 3'b000);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [7:0] v);
    int st = 0;
    mem[a] = v;
    set_addr(a);
    wr(2'd0, 8'h01);
    chk("R7 read data", data, v);
    for (int i = 0; i < 10; i++) begin
      if (stall) st++;
      @(negedge clk);
    end
    chk("R7 read stall", st, 4);
  endtask

  task automatic t_op(input string tag, input logic [1:0] m, input logic [AW-1:0] a,
                      input logic [7:0] d, input int len, input logic [7:0] expv);
    int cyc = 0;
    int st = 0;
    set_addr(a);
    wr(2'd1, d);
    wr(2'd0, 8'h04);
    wr(2'd0, {2'b00, m, 4'b0010});
    chk({"R2 start ", tag}, ctrl[1], 1'b1);
    while (ctrl[1] && cyc < 1000) begin
      if (stall) st++;
      cyc++;
      @(negedge clk);
    end
    chk({"R4 length ", tag}, cyc, len);
    chk({"R8 stall ", tag}, st, 2);
    chk({"R5 commit ", tag}, {cv, ce, cp}, {1'b1, m != 2'b10, m != 2'b01});
    @(negedge clk);
    chk({"R11 cell ", tag}, mem[a], expv);
  endtask

  task automatic t_arm_window();
    int n = 0;
    wr(2'd0, 8'h04);
    for (int i = 0; i < 8; i++) begin
      if (ctrl[2]) n++;
      @(negedge clk);
    end
    chk("R1 arm cycles", n, 4);
    // late start, fifth edge after arming
    wr(2'd0, 8'h04);
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h12);
    chk("R2 late start ignored", ctrl[1], 1'b0);
    // last legal edge
    wr(2'd0, 8'h04);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h12);
    chk("R2 start at window edge", ctrl[1], 1'b1);
    wait_idle();
    // never armed
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h02);
    chk("R2 no arm", ctrl[1], 1'b0);
  endtask

  task automatic t_reserved();
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h32);
    chk("R3 reserved mode", {ctrl[1], stall}, 2'b00);
  endtask

  task automatic t_busy_ignore();
    set_addr(9'h044);
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h12);
    wr(2'd2, 8'h99);
    chk("R6 addr held", addr, 9'h044);
    wr(2'd0, 8'h21);
    chk("R6 mode held", ctrl[5:4], 2'b01);
    chk("R6 read ignored", {data, stall}, {8'h11, 1'b0});
    wait_idle();
    chk("R6 erase hit captured addr", mem[9'h044], 8'hFF);
  endtask

  task automatic t_irq();
    wr(2'd0, 8'h08);
    chk("R9 irq idle", irq, 1'b1);
    wr(2'd0, 8'h0C);
    wr(2'd0, 8'h1A);
    chk("R9 irq busy", irq, 1'b0);
    wait_idle();
    chk("R9 irq back", irq, 1'b1);
    wr(2'd0, 8'h00);
    chk("R9 irq disabled", irq, 1'b0);
  endtask

  task automatic t_reset_busy();
    mem[9'h077] = 8'h00;
    set_addr(9'h077);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h1A);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 op survives", ctrl[1], 1'b1);
    chk("R10 mode kept", ctrl[5:4], 2'b01);
    chk("R10 cleared fields", {ctrl[3], ctrl[2], 9'(addr)}, {2'b00, 9'h000});
    wait_idle();
    chk("R10 commit after reset", mem[9'h077], 8'hFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 idle reset mode", ctrl, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(9'h005, 8'h3C);
    t_read(9'h1FE, 8'hA7);
    t_op("atomic", 2'b00, 9'h10A, 8'h5A, TA, 8'h5A);
    t_op("erase", 2'b01, 9'h10A, 8'h00, TS, 8'hFF);
    t_op("atomic2", 2'b00, 9'h033, 8'hF3, TA, 8'hF3);
    t_op("write-only", 2'b10, 9'h033, 8'h3F, TS, 8'h33);
    t_arm_window();
    t_reserved();
    t_busy_ignore();
    t_irq();
    t_reset_busy();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule